// File: doc/BRIEF.md
# Sv39 Hardware Page Table Walker

This block turns a 64-bit virtual address into a physical address by walking a three-level radix page table held in memory. A requester presents one translation request at a time: the virtual address and a two-bit access type. Two further inputs give the current root-table setting, a mode value and the physical page number of the root table. The walker fetches 8-byte page table entries through a simple memory request/response port. It then reports either a completed translation or a page fault, each as a one-cycle pulse.

A completed translation returns the physical address, the leaf entry and the level at which the leaf was found. Level 2 is the root, level 1 maps 2 MiB and level 0 maps 4 KiB. The walker handles leaves at every level and rejects superpages whose page number is not aligned to their size. It also rejects non-canonical virtual addresses before it touches memory. When the mode is zero, the walker performs no translation. Caching, permission policy and updates to the accessed and dirty bits belong to the surrounding logic. For that reason the access type is only carried through to the result.

Top module: `ptw_sv39`

## Requirements
- R1: When `root_mode` is 0 on an accepted request, `done` pulses in the cycle after acceptance with `res_pa` equal to the full 64-bit virtual address and `res_level` 0. No memory read is issued.
- R2: With a nonzero `root_mode`, a virtual address whose bits 63..39 are not all equal to bit 38 causes `fault` in the cycle after acceptance, with `res_level` 2 and `res_pte` 0. No memory read is issued.
- R3: The first read goes to byte address {root_ppn, VPN2, 3'b000}. Each later read goes to {ppn of the previous entry, VPN of the current level, 3'b000}, where VPN2 = va[38:30], VPN1 = va[29:21] and VPN0 = va[20:12].
- R4: An entry with V=1 and X,W,R = 000 (bits 3,2,1) is a pointer, so the walk reads the next level down. Its ppn is entry bits 53..10. A pointer met at level 0 causes a fault reported at level 0.
- R5: An entry with V (bit 0) = 0, or with W=1 and R=0, causes a fault at the level where it was read, and no further read is issued.
- R6: A leaf (V=1, X/W/R not all zero) read at level 0 completes with res_pa = {ppn, va[11:0]} and res_level 0.
- R7: A leaf at level 1 completes with res_pa = {ppn[43:9], va[20:0]} when ppn[8:0] is zero. Otherwise it faults at level 1.
- R8: A leaf at level 2 completes with res_pa = {ppn[43:18], va[29:0]} when ppn[17:0] is zero. Otherwise it faults at level 2.
- R9: `req_ready` is high only while idle, and `busy` is high from acceptance of a walk until its result. `done` and `fault` are one-cycle pulses that never occur together. A memory request holds its address steady until accepted.
- R10: With each result, `res_pte` holds the last entry read (0 if none), and `res_acc` echoes the access type of the request. On a fault, `res_pa` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to accept |
| req_vaddr | input | 64 | Virtual address to translate |
| req_acc | input | 2 | Access type, carried to the result |
| root_mode | input | 4 | Translation mode; 0 bypasses translation |
| root_ppn | input | 44 | Physical page number of the root table |
| mem_req_valid | output | 1 | Entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 56 | Byte address of the 8-byte entry |
| mem_resp_valid | input | 1 | Read data present |
| mem_resp_ready | output | 1 | Walker waiting for read data |
| mem_resp_data | input | 64 | Entry read from memory |
| busy | output | 1 | Walk in progress |
| done | output | 1 | Translation completed (pulse) |
| fault | output | 1 | Page fault (pulse) |
| res_pa | output | 64 | Physical address, zero-extended |
| res_pte | output | 64 | Last entry read |
| res_level | output | 2 | Level of the leaf or of the fault |
| res_acc | output | 2 | Access type of the finished request |

## Verification
On every cycle, the assertions check several rules. Bypass and non-canonical requests must finish one cycle after acceptance without a memory read. The first read must land in the root table, reads must be 8-byte aligned and held until accepted, and result pulses must be exclusive and single-cycle. A completed superpage must carry an aligned page number. Only the bench scenarios can show the rest, because that depends on table contents built per case. This covers the address of each later read, the physical address assembled for each page size and virtual address, and the level at which pointer chains, invalid encodings and misaligned superpages fault. The bench sweeps leaf level, permission encoding, alignment and both address halves, with a memory model that varies its stall and latency.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
  localparam int VA_W        = 64;
  localparam int OFF_W       = 12;
  localparam int IDX_W       = 9;
  localparam int LVLS        = 3;
  localparam int PPN_W       = 44;
  localparam int PTE_W       = 64;
  localparam int MODE_W      = 4;
  localparam int ACC_W       = 2;
  localparam int ENT_B       = 3;
  localparam int PTE_PPN_LSB = 10;
  localparam int LVL_W       = $clog2(LVLS);
  localparam int VAT_W       = OFF_W + IDX_W * LVLS;
  localparam int PA_W        = PPN_W + OFF_W;
  localparam int SX_W        = VA_W - VAT_W + 1;
  localparam int LO_W        = VAT_W - IDX_W;
  localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(LVLS - 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_MREQ  = 2'd1,
    ST_MWAIT = 2'd2
  } walk_state_e;

  typedef enum logic [1:0] {
    PK_FAULT = 2'd0,
    PK_NEXT  = 2'd1,
    PK_LEAF  = 2'd2
  } pte_kind_e;
endpackage

// File: rtl/ptw_canon_chk.sv
module ptw_canon_chk
  import ptw_pkg::*;
(
  input  logic [SX_W-1:0] hi_bits,
  output logic            canon
);
  // Canonical when the extension bits and the top translated bit agree.
  assign canon = (&hi_bits) | ~(|hi_bits);
endmodule

// File: rtl/ptw_va_index.sv
module ptw_va_index
  import ptw_pkg::*;
(
  input  logic [IDX_W*LVLS-1:0] vpns,
  input  logic [LVL_W-1:0]      lvl,
  output logic [IDX_W-1:0]      idx
);
  logic [IDX_W-1:0] vpn_a [LVLS];

  for (genvar g = 0; g < LVLS; g++) begin : g_vpn
    assign vpn_a[g] = vpns[g*IDX_W +: IDX_W];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < LVLS; i++) begin
      if (lvl == LVL_W'(i)) idx = vpn_a[i];
    end
  end
endmodule

// File: rtl/ptw_pte_eval.sv
module ptw_pte_eval
  import ptw_pkg::*;
(
  input  logic [3:0]       xwrv,
  input  logic [PPN_W-1:0] ppn,
  input  logic [LVL_W-1:0] lvl,
  output pte_kind_e        kind
);
  logic [LVLS-1:0] low_clear;
  logic            aligned;
  logic            v_bit, r_bit, w_bit, x_bit;

  assign v_bit = xwrv[0];
  assign r_bit = xwrv[1];
  assign w_bit = xwrv[2];
  assign x_bit = xwrv[3];

  // A leaf at level g must have its low g*IDX_W page-number bits clear.
  for (genvar g = 0; g < LVLS; g++) begin : g_align
    if (g == 0) begin : g_base
      assign low_clear[g] = 1'b1;
    end else begin : g_super
      assign low_clear[g] = ~(|ppn[g*IDX_W-1:0]);
    end
  end

  always_comb begin
    aligned = 1'b0;
    for (int i = 0; i < LVLS; i++) begin
      if (lvl == LVL_W'(i)) aligned = low_clear[i];
    end
  end

  always_comb begin
    kind = PK_FAULT;
    if (v_bit && !(w_bit && !r_bit)) begin
      if (!(x_bit || w_bit || r_bit)) begin
        kind = (lvl == '0) ? PK_FAULT : PK_NEXT;
      end else begin
        kind = aligned ? PK_LEAF : PK_FAULT;
      end
    end
  end
endmodule

// File: rtl/ptw_pa_form.sv
module ptw_pa_form
  import ptw_pkg::*;
(
  input  logic [PPN_W-1:0] ppn,
  input  logic [LO_W-1:0]  va_lo,
  input  logic [LVL_W-1:0] lvl,
  output logic [PA_W-1:0]  pa
);
  logic [PA_W-1:0] cand [LVLS];

  // Per level: upper page number bits joined with the untranslated VA bits.
  for (genvar g = 0; g < LVLS; g++) begin : g_cand
    assign cand[g] = {ppn[PPN_W-1:g*IDX_W], va_lo[OFF_W+g*IDX_W-1:0]};
  end

  always_comb begin
    pa = '0;
    for (int i = 0; i < LVLS; i++) begin
      if (lvl == LVL_W'(i)) pa = cand[i];
    end
  end
endmodule

// File: rtl/ptw_sv39.sv
module ptw_sv39
  import ptw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VA_W-1:0]   req_vaddr,
  input  logic [ACC_W-1:0]  req_acc,
  input  logic [MODE_W-1:0] root_mode,
  input  logic [PPN_W-1:0]  root_ppn,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [PA_W-1:0]   mem_req_addr,
  input  logic              mem_resp_valid,
  output logic              mem_resp_ready,
  input  logic [PTE_W-1:0]  mem_resp_data,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [VA_W-1:0]   res_pa,
  output logic [PTE_W-1:0]  res_pte,
  output logic [LVL_W-1:0]  res_level,
  output logic [ACC_W-1:0]  res_acc
);
  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rs_q;
  logic       rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  walk_state_e       state_q, state_d;
  logic [VAT_W-1:0]  va_q;
  logic [ACC_W-1:0]  acc_q;
  logic [LVL_W-1:0]  lvl_q, lvl_d;
  logic [PPN_W-1:0]  base_q, base_d;
  logic              done_q, done_d;
  logic              fault_q, fault_d;
  logic [VA_W-1:0]   pa_q, pa_d;
  logic [PTE_W-1:0]  pte_q, pte_d;
  logic [LVL_W-1:0]  rlvl_q, rlvl_d;
  logic              accept, walk_ld, res_en;

  logic              canon;
  logic [IDX_W-1:0]  cur_idx;
  pte_kind_e         kind;
  logic [PPN_W-1:0]  resp_ppn;
  logic [PA_W-1:0]   leaf_pa;

  assign resp_ppn = mem_resp_data[PTE_PPN_LSB +: PPN_W];

  ptw_canon_chk u_canon (
    .hi_bits (req_vaddr[VA_W-1:VAT_W-1]),
    .canon   (canon)
  );

  ptw_va_index u_index (
    .vpns (va_q[VAT_W-1:OFF_W]),
    .lvl  (lvl_q),
    .idx  (cur_idx)
  );

  ptw_pte_eval u_eval (
    .xwrv (mem_resp_data[3:0]),
    .ppn  (resp_ppn),
    .lvl  (lvl_q),
    .kind (kind)
  );

  ptw_pa_form u_pa (
    .ppn   (resp_ppn),
    .va_lo (va_q[LO_W-1:0]),
    .lvl   (lvl_q),
    .pa    (leaf_pa)
  );

  assign req_ready      = (state_q == ST_IDLE);
  assign accept         = req_valid && req_ready;
  assign mem_req_valid  = (state_q == ST_MREQ);
  assign mem_resp_ready = (state_q == ST_MWAIT);
  assign mem_req_addr   = {base_q, cur_idx, {ENT_B{1'b0}}};
  assign busy           = (state_q != ST_IDLE);

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    lvl_d   = lvl_q;
    base_d  = base_q;
    walk_ld = 1'b0;
    done_d  = 1'b0;
    fault_d = 1'b0;
    pa_d    = pa_q;
    pte_d   = pte_q;
    rlvl_d  = rlvl_q;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (root_mode == '0) begin
            done_d = 1'b1;
            pa_d   = req_vaddr;
            pte_d  = '0;
            rlvl_d = '0;
          end else if (!canon) begin
            fault_d = 1'b1;
            pa_d    = '0;
            pte_d   = '0;
            rlvl_d  = TOP_LVL;
          end else begin
            state_d = ST_MREQ;
            walk_ld = 1'b1;
            lvl_d   = TOP_LVL;
            base_d  = root_ppn;
          end
        end
      end
      ST_MREQ: begin
        if (mem_req_ready) state_d = ST_MWAIT;
      end
      ST_MWAIT: begin
        if (mem_resp_valid) begin
          pte_d  = mem_resp_data;
          rlvl_d = lvl_q;
          unique case (kind)
            PK_LEAF: begin
              done_d  = 1'b1;
              pa_d    = VA_W'(leaf_pa);
              state_d = ST_IDLE;
            end
            PK_NEXT: begin
              walk_ld = 1'b1;
              base_d  = resp_ppn;
              lvl_d   = lvl_q - LVL_W'(1);
              state_d = ST_MREQ;
            end
            default: begin
              fault_d = 1'b1;
              pa_d    = '0;
              state_d = ST_IDLE;
            end
          endcase
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign res_en = done_d || fault_d;

  // Registers with explicit enables.
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      va_q    <= '0;
      acc_q   <= '0;
      lvl_q   <= '0;
      base_q  <= '0;
      pa_q    <= '0;
      pte_q   <= '0;
      rlvl_q  <= '0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      fault_q <= fault_d;
      if (accept) begin
        va_q  <= req_vaddr[VAT_W-1:0];
        acc_q <= req_acc;
      end
      if (walk_ld) begin
        lvl_q  <= lvl_d;
        base_q <= base_d;
      end
      if (res_en) begin
        pa_q   <= pa_d;
        pte_q  <= pte_d;
        rlvl_q <= rlvl_d;
      end
    end
  end

  assign done      = done_q;
  assign fault     = fault_q;
  assign res_pa    = pa_q;
  assign res_pte   = pte_q;
  assign res_level = rlvl_q;
  assign res_acc   = acc_q;
endmodule

// File: rtl/ptw_sv39_sva.sv
module ptw_sv39_sva
  import ptw_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [VA_W-1:0]   req_vaddr,
  input logic [ACC_W-1:0]  req_acc,
  input logic [MODE_W-1:0] root_mode,
  input logic [PPN_W-1:0]  root_ppn,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [PA_W-1:0]   mem_req_addr,
  input logic              mem_resp_valid,
  input logic              mem_resp_ready,
  input logic [PTE_W-1:0]  mem_resp_data,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [VA_W-1:0]   res_pa,
  input logic [PTE_W-1:0]  res_pte,
  input logic [LVL_W-1:0]  res_level,
  input logic [ACC_W-1:0]  res_acc
);
  logic acc_req, hi_ok;
  assign acc_req = req_valid && req_ready;
  assign hi_ok   = (req_vaddr[VA_W-1:VAT_W-1] == '0) || (req_vaddr[VA_W-1:VAT_W-1] == '1);

  p_bypass_done_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && root_mode == '0) |=> (done && res_pa == $past(req_vaddr) && !mem_req_valid));

  p_sign_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && root_mode != '0 && !hi_ok) |=> (fault && !mem_req_valid && res_level == TOP_LVL));

  p_root_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_req && root_mode != '0 && hi_ok) |=>
      (mem_req_valid && mem_req_addr[PA_W-1:OFF_W] == $past(root_ppn)));

  p_addr_align_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[ENT_B-1:0] == '0));

  p_invalid_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_resp_valid && mem_resp_ready && !mem_resp_data[0]) |=> (fault && !done));

  p_leaf_bits_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_resp_valid)) |-> (res_pte[0] && res_pte[3:1] != 3'b000));

  p_mega_align_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_resp_valid) && res_level == LVL_W'(1)) |->
      (res_pte[PTE_PPN_LSB +: IDX_W] == '0));

  p_giga_align_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(mem_resp_valid) && res_level == LVL_W'(2)) |->
      (res_pte[PTE_PPN_LSB +: 2*IDX_W] == '0));

  p_excl_r9: assert property (@(posedge clk) disable iff (!rst_n) !(done && fault));

  p_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done || fault) |=> !(done || fault));

  p_busy_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !req_ready);

  p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_fault_pa_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (res_pa == '0));
endmodule

bind ptw_sv39 ptw_sv39_sva u_sva (.*);

// File: tb/ptw_sv39_tb.sv
module ptw_sv39_tb;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic        req_ready;
  logic [63:0] req_vaddr;
  logic [1:0]  req_acc;
  logic [3:0]  root_mode;
  logic [43:0] root_ppn;
  logic        mem_req_valid;
  logic        mem_req_ready;
  logic [55:0] mem_req_addr;
  logic        mem_resp_valid;
  logic        mem_resp_ready;
  logic [63:0] mem_resp_data;
  logic        busy, done, fault;
  logic [63:0] res_pa, res_pte;
  logic [1:0]  res_level, res_acc;

  always #2.5 clk = ~clk;

  ptw_sv39 u_dut (.*);

  localparam logic [43:0] ROOT = 44'h80400;
  localparam logic [43:0] T1   = 44'h80401;
  localparam logic [43:0] T0   = 44'h80402;

  logic [63:0] pmem [logic [55:0]];
  int          nchk = 0;
  int          nerr = 0;
  int          rd_cnt;
  logic [55:0] seen [4];
  logic        r_done, r_fault, r_busy_end, r_pulse_after, r_overlap;
  logic [63:0] r_pa, r_pte;
  logic [1:0]  r_lvl, r_acc;

  function automatic logic [55:0] ea(input logic [43:0] tp, input logic [8:0] ix);
    return {tp, ix, 3'b000};
  endfunction

  function automatic logic [63:0] ptr(input logic [43:0] p);
    return (64'(p) << 10) | 64'h1;
  endfunction

  function automatic logic [63:0] leaf(input logic [43:0] p, input logic [2:0] xwr);
    return (64'(p) << 10) | 64'hC0 | (64'(xwr) << 1) | 64'h1;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Memory model: variable stall before accepting, variable response latency.
  initial begin
    mem_req_ready  = 1'b0;
    mem_resp_valid = 1'b0;
    mem_resp_data  = '0;
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [55:0] a;
        int st, lt;
        a  = mem_req_addr;
        st = rd_cnt % 3;
        lt = rd_cnt % 2;
        if (rd_cnt < 4) seen[rd_cnt] = a;
        rd_cnt++;
        repeat (st) @(negedge clk);
        chk("R9 request address held", 64'(mem_req_addr), 64'(a));
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        repeat (lt) @(negedge clk);
        mem_resp_data  = pmem.exists(a) ? pmem[a] : 64'h0;
        mem_resp_valid = 1'b1;
        @(negedge clk);
        mem_resp_valid = 1'b0;
      end
    end
  end

  task automatic run(input logic [63:0] va, input logic [3:0] mode, input logic [1:0] acc);
    int cyc;
    rd_cnt = 0;
    r_overlap = 1'b0;
    @(negedge clk);
    req_vaddr = va;
    root_mode = mode;
    root_ppn  = ROOT;
    req_acc   = acc;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    cyc = 0;
    while (!(done || fault) && cyc < 500) begin
      if (busy && req_ready) r_overlap = 1'b1;
      @(negedge clk);
      cyc++;
    end
    r_done = done; r_fault = fault; r_pa = res_pa; r_pte = res_pte;
    r_lvl = res_level; r_acc = res_acc; r_busy_end = busy;
    @(negedge clk);
    r_pulse_after = done || fault;
  endtask

  task automatic expect_res(input string tag, input logic ef, input logic [63:0] epa,
                            input logic [1:0] elv, input logic [63:0] epte,
                            input int erd, input logic [1:0] eacc);
    chk({tag, " outcome"}, {62'b0, r_fault, r_done}, ef ? 64'd2 : 64'd1);
    chk({tag, " pa (R10 when fault)"}, r_pa, epa);
    chk({tag, " level"}, 64'(r_lvl), 64'(elv));
    chk({tag, " R10 pte"}, r_pte, epte);
    chk({tag, " R10 acc echo"}, 64'(r_acc), 64'(eacc));
    chk({tag, " read count"}, 64'(rd_cnt), 64'(erd));
    chk({tag, " R9 handshake"}, {61'b0, r_overlap, r_busy_end, r_pulse_after}, 64'd0);
  endtask

  // Builds a chain down to level lv and places entry e there.
  task automatic build(input logic [63:0] va, input int lv, input logic [63:0] e);
    pmem.delete();
    if (lv == 2) pmem[ea(ROOT, va[38:30])] = e;
    else begin
      pmem[ea(ROOT, va[38:30])] = ptr(T1);
      if (lv == 1) pmem[ea(T1, va[29:21])] = e;
      else begin
        pmem[ea(T1, va[29:21])] = ptr(T0);
        pmem[ea(T0, va[20:12])] = e;
      end
    end
  endtask

  task automatic chk_addrs(input string tag, input logic [63:0] va, input int n);
    logic [55:0] ex [3];
    ex[0] = ea(ROOT, va[38:30]);
    ex[1] = ea(T1, va[29:21]);
    ex[2] = ea(T0, va[20:12]);
    for (int k = 0; k < n && k < 3; k++)
      chk({tag, " R3 read address"}, 64'(seen[k]), 64'(ex[k]));
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [63:0] vas [2];
    logic [2:0]  xwrs [5];
    vas[0] = 64'h0000_0000_8020_1234;
    vas[1] = 64'hffff_ffd1_dead_beef;
    xwrs[0] = 3'b001; xwrs[1] = 3'b011; xwrs[2] = 3'b100;
    xwrs[3] = 3'b101; xwrs[4] = 3'b111;
    req_valid = 1'b0; req_vaddr = '0; req_acc = '0;
    root_mode = '0; root_ppn = '0;
    rd_cnt = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R9 reset idle", {59'b0, busy, done, fault, mem_req_valid, req_ready}, 64'd1);

    // R1: bypass
    run(64'h8000_0000_0000_0abc, 4'd0, 2'd3);
    expect_res("R1 bypass high", 1'b0, 64'h8000_0000_0000_0abc, 2'd0, 64'd0, 0, 2'd3);
    run(64'h0000_0000_8020_1234, 4'd0, 2'd1);
    expect_res("R1 bypass low", 1'b0, 64'h0000_0000_8020_1234, 2'd0, 64'd0, 0, 2'd1);

    // R2: non-canonical addresses
    begin
      logic [63:0] bad [3];
      bad[0] = 64'h0000_0040_0000_0000;
      bad[1] = 64'h8000_0000_0000_0000;
      bad[2] = 64'hffff_ff80_0000_1000;
      for (int b = 0; b < 3; b++) begin
        pmem.delete();
        run(bad[b], 4'd8, 2'd2);
        expect_res("R2 non-canonical", 1'b1, 64'd0, 2'd2, 64'd0, 0, 2'd2);
      end
    end

    // R4 R6 R7 R8: leaf sweep over level, permissions, alignment, address half
    for (int lv = 0; lv < 3; lv++) begin
      for (int vi = 0; vi < 2; vi++) begin
        for (int fi = 0; fi < 5; fi++) begin
          for (int mis = 0; mis < ((lv > 0) ? 2 : 1); mis++) begin
            logic [43:0] p;
            logic [63:0] e, epa, msk;
            string tg;
            p = 44'h2AB5 << (9 * lv);
            if (mis != 0) p = p | (44'h1 << ((lv == 2) ? 12 : 3));
            e = leaf(p, xwrs[fi]);
            build(vas[vi], lv, e);
            run(vas[vi], 4'd8, 2'(fi));
            tg = (lv == 0) ? "R6 4K leaf" : (lv == 1) ? "R7 2M leaf" : "R8 1G leaf";
            msk = (64'h1 << (12 + 9 * lv)) - 64'h1;
            epa = (64'(p) << 12) + (vas[vi] & msk);
            if (mis != 0) expect_res({tg, " misaligned"}, 1'b1, 64'd0, 2'(lv), e, 3 - lv, 2'(fi));
            else          expect_res({tg, " R4 walk"}, 1'b0, epa, 2'(lv), e, 3 - lv, 2'(fi));
            chk_addrs(tg, vas[vi], 3 - lv);
          end
        end
      end
    end

    // R5: invalid encodings at each level
    for (int lv = 0; lv < 3; lv++) begin
      for (int k = 0; k < 3; k++) begin
        logic [63:0] e;
        e = (k == 0) ? (64'h2AB5 << 10) | 64'h0E :
            (k == 1) ? leaf(44'h0, 3'b010) : leaf(44'h0, 3'b110);
        build(vas[k % 2], lv, e);
        run(vas[k % 2], 4'd8, 2'd0);
        expect_res("R5 invalid entry", 1'b1, 64'd0, 2'(lv), e, 3 - lv, 2'd0);
        chk_addrs("R5", vas[k % 2], 3 - lv);
      end
    end

    // R4: pointer at level 0, and empty table
    build(vas[1], 0, ptr(44'h12345));
    run(vas[1], 4'd8, 2'd1);
    expect_res("R4 pointer at level 0", 1'b1, 64'd0, 2'd0, ptr(44'h12345), 3, 2'd1);
    pmem.delete();
    run(vas[0], 4'd8, 2'd1);
    expect_res("R5 empty root", 1'b1, 64'd0, 2'd2, 64'd0, 1, 2'd1);

    summary();
    $finish;
  end
endmodule